// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel that sits next to a free-running timer counter. It keeps one channel register, and a 2-bit direction field decides what that register does. With the field at 00 the register holds a compare value. The channel then builds a reference waveform from the counter: it can hold, set, clear or toggle on a match, force a fixed level, or produce one of two PWM levels. A polarity bit and an enable bit turn that reference into the pin drive. With the field at 01 or 10 the register captures. The channel watches a synchronized input pin for a chosen edge, can divide the edge events down, and latches the counter value on each qualified event.

One event flag is set by every capture and by every compare match. A separate overcapture flag records that a capture arrived while the event flag was still pending. Software can clear the event flag by writing zero to it, or by reading the capture register. The overcapture flag clears only on its own clear strobe. The interrupt request is the event flag gated by an interrupt enable.

Top module: `cc_channel`

## Requirements
- R1: After reset, the channel register, the event flag, the overcapture flag, the reference, the pin and the pin enable are all 0.
- R2: `dir_sel` 00 selects output (compare) mode. 01 selects capture from `pin_own`. 10 selects capture from `pin_pair`. While 01 is selected, edges on the other pin cause no capture.
- R3: An input change is seen through a two-flop synchronizer. The capture lands on the third rising clock edge after the pin changes. At that edge `ccr_q` takes the `cnt_val` present at it and `evt_flag` goes to 1. No capture happens while `ch_en` is 0.
- R4: `pol_bits` selects the capture edge: 00 rising, 01 falling, 11 both edges. 10 is reserved and captures nothing.
- R5: `in_psc` sets which qualified edge captures: 00 every edge, 01 every 2nd, 10 every 4th, 11 every 8th. The edge count restarts while `ch_en` is 0.
- R6: A capture while `evt_flag` is already 1 sets `ovr_flag`. `ovr_flag` clears only on `ovr_clr`, and neither `flag_clr` nor `ccr_rd` affects it.
- R7: `evt_flag` clears one edge after `flag_clr`, or after `ccr_rd` in capture mode. A set in the same cycle as a clear wins.
- R8: `ccr_wr` loads `ccr_wdata` in output mode and is ignored in capture mode.
- R9: A match is the first cycle in which `cnt_val` equals `ccr_q`. On the edge that ends that cycle, `evt_flag` is set and the reference follows `oc_mode`: 000 hold, 001 set, 010 clear, 011 toggle. Holding the counter at the same value does not repeat the match.
- R10: `oc_mode` 100 forces the reference to 0 and 101 forces it to 1 on the next edge. A match still sets `evt_flag` in these modes.
- R11: `oc_mode` 110 makes the reference 1 while counting up with `cnt_val < ccr_q`, and 1 while counting down with `cnt_val <= ccr_q`; otherwise it is 0. `oc_mode` 111 gives the inverse. The reference is registered, one edge after the counter value.
- R12: `oc_pin_oe` is `ch_en` in output mode and 0 otherwise. `oc_pin` is `oc_ref` XOR `pol_bits[0]` when `oc_pin_oe` is 1, and 0 otherwise.
- R13: `irq` is `evt_flag` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current timer counter value |
| cnt_up | input | 1 | Counter direction, 1 = counting up |
| dir_sel | input | 2 | Channel direction / input source select |
| oc_mode | input | 3 | Output reference mode |
| pol_bits | input | 2 | Bit 0 output polarity; both bits select the capture edge |
| ch_en | input | 1 | Channel enable (pin drive or capture) |
| in_psc | input | PSC_W | Capture event divider select |
| irq_en | input | 1 | Interrupt enable |
| ccr_wr | input | 1 | Channel register write strobe |
| ccr_wdata | input | CNT_W | Channel register write data |
| ccr_rd | input | 1 | Channel register read strobe |
| flag_clr | input | 1 | Write-zero strobe for the event flag |
| ovr_clr | input | 1 | Write-zero strobe for the overcapture flag |
| pin_own | input | 1 | Channel's own input pin |
| pin_pair | input | 1 | Neighbouring channel's input pin |
| ccr_q | output | CNT_W | Channel register (compare or captured value) |
| evt_flag | output | 1 | Event flag |
| ovr_flag | output | 1 | Overcapture flag |
| oc_ref | output | 1 | Output reference |
| oc_pin | output | 1 | Pin drive value |
| oc_pin_oe | output | 1 | Pin drive enable |
| irq | output | 1 | Interrupt request |

## Verification
A capture is due on the third rising edge after the pin moves. Each capture scenario therefore steps two edges and confirms that nothing has changed yet, then steps one more edge and checks the latched value and the flag. Compare matches, forced levels, PWM levels and strobe-driven clears each land on the first edge after the stimulus, so those checks sample one edge later. The pin drive, pin enable and interrupt are combinational from registered state and configuration, so they are checked in the same half cycle in which the configuration changes. All inputs change on the falling edge and all outputs are read on a falling edge, half a period away from the registers.

// File: rtl/cc_chan_pkg.sv
package cc_chan_pkg;

  typedef enum logic [2:0] {
    OC_HOLD  = 3'b000,
    OC_SET   = 3'b001,
    OC_CLR   = 3'b010,
    OC_TOG   = 3'b011,
    OC_LOW   = 3'b100,
    OC_HIGH  = 3'b101,
    OC_PWM_A = 3'b110,
    OC_PWM_B = 3'b111
  } oc_mode_e;

  // PWM "active" level for the first PWM flavour, direction aware
  function automatic logic pwm_active(logic [31:0] cnt, logic [31:0] cmp, logic up);
    return up ? (cnt < cmp) : (cnt <= cmp);
  endfunction

  // Qualified edge from previous/current sampled level and edge select
  function automatic logic edge_hit(logic prev, logic cur, logic [1:0] sel);
    case (sel)
      2'b00:   return !prev && cur;
      2'b01:   return prev && !cur;
      2'b11:   return prev ^ cur;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cc_in_stage.sv
module cc_in_stage #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pins,      // [0] own, [1] neighbour
  input  logic [1:0] src_sel,
  input  logic [1:0] edge_sel,
  input  logic       arm,
  output logic       edge_evt
);
  import cc_chan_pkg::*;

  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_sh [2];
  logic sel_now, prev_q;

  for (genvar p = 0; p < 2; p++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_sh[p] <= '0;
      else        sync_sh[p] <= {sync_sh[p][SYNC_STAGES-2:0], pins[p]};
    end
  end

  assign sel_now = (src_sel == 2'b01) ? sync_sh[0][MSB] : sync_sh[1][MSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel_now;
  end

  assign edge_evt = arm && (src_sel != 2'b00) && edge_hit(prev_q, sel_now, edge_sel);

endmodule

// File: rtl/cc_evt_div.sv
module cc_evt_div #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_evt,
  input  logic [PSC_W-1:0] psc,
  input  logic             restart,
  output logic             cap_evt
);
  localparam int CNT_W = (1 << PSC_W) - 1;

  logic [CNT_W-1:0] cnt_q, last;

  assign last    = CNT_W'((32'd1 << psc) - 32'd1);
  assign cap_evt = edge_evt && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (edge_evt) cnt_q <= cap_evt ? '0 : cnt_q + 1'b1;
  end

  // R5
  div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && psc != '0 && !restart) |=> !cap_evt);

endmodule

// File: rtl/cc_ref_gen.sv
module cc_ref_gen #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [CNT_W-1:0]      cmp,
  input  logic                  cnt_up,
  input  logic                  out_mode,
  input  cc_chan_pkg::oc_mode_e mode,
  output logic                  ref_q,
  output logic                  match_evt
);
  import cc_chan_pkg::*;

  logic eq, eq_q, ref_nxt, pwm_a;

  assign eq        = (cnt == cmp);
  assign match_evt = out_mode && eq && !eq_q;
  assign pwm_a     = pwm_active(32'(cnt), 32'(cmp), cnt_up);

  always_comb begin
    case (mode)
      OC_HOLD:  ref_nxt = ref_q;
      OC_SET:   ref_nxt = match_evt ? 1'b1 : ref_q;
      OC_CLR:   ref_nxt = match_evt ? 1'b0 : ref_q;
      OC_TOG:   ref_nxt = match_evt ? !ref_q : ref_q;
      OC_LOW:   ref_nxt = 1'b0;
      OC_HIGH:  ref_nxt = 1'b1;
      OC_PWM_A: ref_nxt = pwm_a;
      OC_PWM_B: ref_nxt = !pwm_a;
      default:  ref_nxt = ref_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q  <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      eq_q <= eq;
      if (out_mode) ref_q <= ref_nxt;
    end
  end

  // R10
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && mode == OC_HIGH) |=> ref_q);

  // R9
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && mode == OC_TOG && match_evt) |=> (ref_q != $past(ref_q)));

endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_up,
  input  logic [1:0]       dir_sel,
  input  logic [2:0]       oc_mode,
  input  logic [1:0]       pol_bits,
  input  logic             ch_en,
  input  logic [PSC_W-1:0] in_psc,
  input  logic             irq_en,
  input  logic             ccr_wr,
  input  logic [CNT_W-1:0] ccr_wdata,
  input  logic             ccr_rd,
  input  logic             flag_clr,
  input  logic             ovr_clr,
  input  logic             pin_own,
  input  logic             pin_pair,
  output logic [CNT_W-1:0] ccr_q,
  output logic             evt_flag,
  output logic             ovr_flag,
  output logic             oc_ref,
  output logic             oc_pin,
  output logic             oc_pin_oe,
  output logic             irq
);
  import cc_chan_pkg::*;

  logic in_mode, out_mode;
  logic edge_evt, cap_evt, match_evt;
  logic flag_set, flag_drop;

  assign in_mode  = (dir_sel != 2'b00);
  assign out_mode = !in_mode;

  cc_in_stage #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     ({pin_pair, pin_own}),
    .src_sel  (dir_sel),
    .edge_sel (pol_bits),
    .arm      (ch_en),
    .edge_evt (edge_evt)
  );

  cc_evt_div #(.PSC_W(PSC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_evt (edge_evt),
    .psc      (in_psc),
    .restart  (!ch_en || out_mode),
    .cap_evt  (cap_evt)
  );

  cc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_val),
    .cmp       (ccr_q),
    .cnt_up    (cnt_up),
    .out_mode  (out_mode),
    .mode      (oc_mode_e'(oc_mode)),
    .ref_q     (oc_ref),
    .match_evt (match_evt)
  );

  assign flag_set  = cap_evt || match_evt;
  assign flag_drop = flag_clr || (ccr_rd && in_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q    <= '0;
      evt_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (cap_evt)                 ccr_q <= cnt_val;
      else if (ccr_wr && out_mode) ccr_q <= ccr_wdata;

      if (flag_set)       evt_flag <= 1'b1;
      else if (flag_drop) evt_flag <= 1'b0;

      if (cap_evt && evt_flag) ovr_flag <= 1'b1;
      else if (ovr_clr)        ovr_flag <= 1'b0;
    end
  end

  assign oc_pin_oe = ch_en && out_mode;
  assign oc_pin    = oc_pin_oe ? (oc_ref ^ pol_bits[0]) : 1'b0;
  assign irq       = evt_flag && irq_en;

  // R3
  capture_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ccr_q == $past(cnt_val)) && evt_flag);

  // R6
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(evt_flag) && $past(cap_evt));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  // R8
  ccr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !cap_evt) |=> $stable(ccr_q));

endmodule

// File: tb/cc_channel_test.sv
`timescale 1ns/1ps
module cc_channel_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic cnt_up = 1'b1;
  logic [1:0] dir_sel = 2'b01;
  logic [2:0] oc_mode = 3'b000;
  logic [1:0] pol_bits = 2'b00;
  logic ch_en = 1'b0;
  logic [1:0] in_psc = 2'b00;
  logic irq_en = 1'b0;
  logic ccr_wr = 1'b0;
  logic [CW-1:0] ccr_wdata = '0;
  logic ccr_rd = 1'b0, flag_clr = 1'b0, ovr_clr = 1'b0;
  logic pin_own = 1'b0, pin_pair = 1'b0;
  logic [CW-1:0] ccr_q;
  logic evt_flag, ovr_flag, oc_ref, oc_pin, oc_pin_oe, irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  cc_channel #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
    .dir_sel(dir_sel), .oc_mode(oc_mode), .pol_bits(pol_bits), .ch_en(ch_en),
    .in_psc(in_psc), .irq_en(irq_en), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
    .ccr_rd(ccr_rd), .flag_clr(flag_clr), .ovr_clr(ovr_clr),
    .pin_own(pin_own), .pin_pair(pin_pair), .ccr_q(ccr_q),
    .evt_flag(evt_flag), .ovr_flag(ovr_flag), .oc_ref(oc_ref),
    .oc_pin(oc_pin), .oc_pin_oe(oc_pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_flags();
    flag_clr = 1'b1; ovr_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic pulse_own(input logic [CW-1:0] c);
    cnt_val = c; pin_own = 1'b1; tick(3);
    pin_own = 1'b0; tick(3);
  endtask

  task automatic wr_ccr(input logic [CW-1:0] v);
    ccr_wr = 1'b1; ccr_wdata = v; tick(1); ccr_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ccr", 32'(ccr_q), 0);
    check("R1 flag", 32'(evt_flag), 0);
    check("R1 ovr", 32'(ovr_flag), 0);
    check("R1 ref", 32'(oc_ref), 0);
    check("R1 pin", 32'(oc_pin), 0);
    check("R1 oe", 32'(oc_pin_oe), 0);
  endtask

  task automatic t_capture();
    dir_sel = 2'b01; ch_en = 1'b1; cnt_val = 100; tick(1);
    pin_own = 1'b1; tick(2);
    check("R3 not before third edge", 32'(evt_flag), 0);
    tick(1);
    check("R3 latched value", 32'(ccr_q), 100);
    check("R3 flag set", 32'(evt_flag), 1);
    pin_own = 1'b0; tick(3);
    clr_flags();
    ch_en = 1'b0; cnt_val = 200; pin_own = 1'b1; tick(3);
    check("R3 disabled no capture", 32'(ccr_q), 100);
    check("R3 disabled no flag", 32'(evt_flag), 0);
    pin_own = 1'b0; tick(3); ch_en = 1'b1;
  endtask

  task automatic t_pair();
    dir_sel = 2'b10; cnt_val = 300;
    pulse_own(300);
    check("R2 own pin ignored in pair mode", 32'(ccr_q), 100);
    pin_pair = 1'b1; tick(3);
    check("R2 pair capture", 32'(ccr_q), 300);
    pin_pair = 1'b0; tick(3);
    dir_sel = 2'b01; tick(1);
    pin_pair = 1'b1; cnt_val = 310; tick(3);
    check("R2 pair pin ignored in own mode", 32'(ccr_q), 300);
    pin_pair = 1'b0; tick(3);
    clr_flags();
  endtask

  task automatic t_edges();
    pol_bits = 2'b01;
    cnt_val = 10; pin_own = 1'b1; tick(3);
    check("R4 falling ignores rise", 32'(evt_flag), 0);
    cnt_val = 11; pin_own = 1'b0; tick(3);
    check("R4 falling capture", 32'(ccr_q), 11);
    clr_flags();
    pol_bits = 2'b11;
    cnt_val = 12; pin_own = 1'b1; tick(3);
    check("R4 both rise", 32'(ccr_q), 12);
    clr_flags();
    cnt_val = 13; pin_own = 1'b0; tick(3);
    check("R4 both fall", 32'(ccr_q), 13);
    clr_flags();
    pol_bits = 2'b10;
    pulse_own(14);
    check("R4 reserved no capture", 32'(ccr_q), 13);
    check("R4 reserved no flag", 32'(evt_flag), 0);
    pol_bits = 2'b00;
  endtask

  task automatic t_psc();
    in_psc = 2'b01;
    pulse_own(20);
    check("R5 div2 first edge", 32'(evt_flag), 0);
    pulse_own(21);
    check("R5 div2 second edge", 32'(ccr_q), 21);
    clr_flags();
    in_psc = 2'b10;
    for (int i = 0; i < 3; i++) pulse_own(CW'(30 + i));
    check("R5 div4 third edge", 32'(evt_flag), 0);
    pulse_own(33);
    check("R5 div4 fourth edge", 32'(ccr_q), 33);
    clr_flags();
    in_psc = 2'b11;
    for (int i = 0; i < 7; i++) pulse_own(CW'(40 + i));
    check("R5 div8 seventh edge", 32'(evt_flag), 0);
    pulse_own(47);
    check("R5 div8 eighth edge", 32'(ccr_q), 47);
    clr_flags();
    in_psc = 2'b01;
    pulse_own(50);
    ch_en = 1'b0; tick(1); ch_en = 1'b1;
    pulse_own(51);
    check("R5 count restarted by disable", 32'(evt_flag), 0);
    pulse_own(52);
    check("R5 capture after restart", 32'(ccr_q), 52);
    clr_flags();
    in_psc = 2'b00;
  endtask

  task automatic t_flags();
    pulse_own(60);
    check("R6 first capture no ovr", 32'(ovr_flag), 0);
    irq_en = 1'b0; #0.1;
    check("R13 irq masked", 32'(irq), 0);
    irq_en = 1'b1; #0.1;
    check("R13 irq raised", 32'(irq), 1);
    pulse_own(61);
    check("R6 ovr set", 32'(ovr_flag), 1);
    check("R6 second value", 32'(ccr_q), 61);
    ccr_rd = 1'b1; tick(1); ccr_rd = 1'b0;
    check("R7 read clears flag", 32'(evt_flag), 0);
    check("R6 read keeps ovr", 32'(ovr_flag), 1);
    check("R13 irq low", 32'(irq), 0);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check("R6 flag_clr keeps ovr", 32'(ovr_flag), 1);
    ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0;
    check("R6 ovr_clr", 32'(ovr_flag), 0);
    pulse_own(62);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check("R7 flag_clr", 32'(evt_flag), 0);
    cnt_val = 63; pin_own = 1'b1; tick(2);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check("R7 set wins over clear", 32'(evt_flag), 1);
    pin_own = 1'b0; tick(3);
    irq_en = 1'b0;
    clr_flags();
  endtask

  task automatic t_lock();
    wr_ccr(999);
    check("R8 write ignored in capture mode", 32'(ccr_q), 63);
    cnt_val = 0; dir_sel = 2'b00; tick(1);
    wr_ccr(999);
    check("R8 write in output mode", 32'(ccr_q), 999);
  endtask

  task automatic t_cmp();
    wr_ccr(50); cnt_val = 0; oc_mode = 3'b001; tick(1); clr_flags();
    check("R9 set no match", 32'(oc_ref), 0);
    cnt_val = 50; tick(1);
    check("R9 set on match", 32'(oc_ref), 1);
    check("R9 flag on match", 32'(evt_flag), 1);
    clr_flags();
    oc_mode = 3'b010; cnt_val = 49; tick(1);
    check("R9 clear waits", 32'(oc_ref), 1);
    cnt_val = 50; tick(1);
    check("R9 clear on match", 32'(oc_ref), 0);
    oc_mode = 3'b011; cnt_val = 0; tick(1);
    cnt_val = 50; tick(1);
    check("R9 toggle up", 32'(oc_ref), 1);
    cnt_val = 51; tick(1); cnt_val = 50; tick(1);
    check("R9 toggle down", 32'(oc_ref), 0);
    tick(2);
    check("R9 held count no repeat", 32'(oc_ref), 0);
  endtask

  task automatic t_forced();
    oc_mode = 3'b101; tick(1);
    check("R10 force high", 32'(oc_ref), 1);
    oc_mode = 3'b000; cnt_val = 0; tick(1); clr_flags();
    cnt_val = 50; tick(1);
    check("R9 hold ignores match", 32'(oc_ref), 1);
    check("R9 hold still flags", 32'(evt_flag), 1);
    clr_flags();
    oc_mode = 3'b100; cnt_val = 0; tick(1);
    check("R10 force low", 32'(oc_ref), 0);
    cnt_val = 50; tick(1);
    check("R10 forced stays low", 32'(oc_ref), 0);
    check("R10 flag in forced mode", 32'(evt_flag), 1);
    clr_flags();
  endtask

  task automatic t_pwm();
    wr_ccr(10); oc_mode = 3'b110; cnt_up = 1'b1;
    cnt_val = 9; tick(1);
    check("R11 pwm1 up below", 32'(oc_ref), 1);
    cnt_val = 10; tick(1);
    check("R11 pwm1 up equal", 32'(oc_ref), 0);
    cnt_val = 11; tick(1);
    check("R11 pwm1 up above", 32'(oc_ref), 0);
    cnt_up = 1'b0; cnt_val = 10; tick(1);
    check("R11 pwm1 down equal", 32'(oc_ref), 1);
    cnt_val = 11; tick(1);
    check("R11 pwm1 down above", 32'(oc_ref), 0);
    cnt_up = 1'b1; oc_mode = 3'b111; cnt_val = 9; tick(1);
    check("R11 pwm2 below", 32'(oc_ref), 0);
    cnt_val = 10; tick(1);
    check("R11 pwm2 equal", 32'(oc_ref), 1);
  endtask

  task automatic t_pin();
    oc_mode = 3'b101; pol_bits = 2'b00; tick(1);
    check("R12 active high pin", 32'(oc_pin), 1);
    check("R12 oe", 32'(oc_pin_oe), 1);
    pol_bits = 2'b01; #0.1;
    check("R12 active low pin", 32'(oc_pin), 0);
    pol_bits = 2'b00; ch_en = 1'b0; #0.1;
    check("R12 disabled pin", 32'(oc_pin), 0);
    check("R12 disabled oe", 32'(oc_pin_oe), 0);
    ch_en = 1'b1; dir_sel = 2'b01; #0.1;
    check("R12 input mode oe", 32'(oc_pin_oe), 0);
    check("R12 input mode pin", 32'(oc_pin), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_capture();
    t_pair();
    t_edges();
    t_psc();
    t_flags();
    t_lock();
    t_cmp();
    t_forced();
    t_pwm();
    t_pin();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule